// File: doc/BRIEF.md
# Serial LED Cascade Driver

This peripheral turns a 24-bit parallel output image into a serial stream for an external chain of 8-bit serial-in, parallel-out shift registers, the kind usually used to light status LEDs. Software configures it and loads the output image over a simple 32-bit register bus. The block drives three lines to the chain: serial data, a shift clock and a store strobe that copies the shifted bits to the register outputs.

Each output bit comes either from the CPU data register or from a side-band status line. Two status lines come from a DSL core and twelve come from four PHYs, three lines each. Per-bit ownership fields in the control registers choose the source for each bit. An update sequence starts when software writes the software-update bit. It can also start on every tick of a built-in refresh timer, which runs from the bus clock at 2, 4, 8 or 10 Hz. The shift clock polarity and the number of enabled 8-bit groups are both programmable.

The sequencer has five states. S_IDLE holds the shift clock at its idle level. When a request is pending and at least one group is enabled, S_IDLE goes to S_SETUP and captures the output image. In S_SETUP the next bit is placed on serial data and the clock is at its idle level. S_SETUP goes to S_SAMPLE after half a shift-clock period. S_SAMPLE drives the clock to its active level. After half a period it goes back to S_SETUP, or to S_STORE_A after the last bit. S_STORE_A and then S_STORE_B each hold the store strobe high for half a period, and S_STORE_B returns to S_IDLE.

Top module: `ledchain_ctrl`

## Requirements
- R1: The registers sit at byte offsets 0x00 (control A), 0x04 (control B), 0x08 (data 0), 0x0C (data 1) and 0x10 (access). All of them read back the last value written. After reset, control A reads 0x8000_0000 and every other register reads 0.
- R2: Writing control A with bit 31 set starts one update sequence. After that sequence's store strobe, external register output k shows image bit k. Bit 0 is shifted out last, so it lands at the first output. The image is captured when the sequence starts.
- R3: Control B bits 2:0 enable the groups. The chain length is 24 bits if bit 2 is set, else 16 if bit 1 is set, else 8 if bit 0 is set. With no group enabled a request produces no sequence and no store strobe.
- R4: Control A bit 26 sets the polarity. With 0 the shift clock idles low and the chain samples on the rising edge. With 1 it idles high and the chain samples on the falling edge. Serial data is stable at every sampling edge.
- R5: Control A bits 25:24 own image bits 1:0. Where an ownership bit is set, image bit k equals dsl_in[k]. Where it is clear, dsl_in has no effect and the bit comes from data 0.
- R6: Each PHY has a 3-bit ownership field, and phy_in[3n+2:3n] belongs to PHY n+1. PHY1 uses control A bits 29:27 and owns image bits 4:2. PHY2 uses control B bits 5:3 and owns bits 7:5. PHY3 uses control B bits 8:6 and owns bits 10:8. PHY4 uses control B bits 17:15 and owns bits 13:11. Image bits 23:14 always come from data 0.
- R7: After the last bit the store strobe is high for one whole shift-clock period, 2*CLK_DIV system clocks.
- R8: A request that arrives while a sequence is running is kept pending. Exactly one more sequence runs when the current one ends, and it uses the image at its own start.
- R9: When control B bits 31:30 equal 2'b10, the refresh timer is on. Control B bits 27:23 pick the period: code 0 gives TICKS_PER_SEC/2 clocks, code 1 gives /4, code 2 gives /8, code 3 gives /10, and any other code gives /2. Each tick starts one sequence. With any other source value no periodic sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| dsl_in | input | 2 | DSL status lines for image bits 1:0 |
| phy_in | input | 12 | Four 3-bit PHY status groups |
| ser_dout | output | 1 | Serial data to the chain |
| ser_clk | output | 1 | Shift clock to the chain |
| ser_store | output | 1 | Store strobe to the chain |

## Verification
The assertions assume that bus_we is never held across back-to-back writes to control A faster than the sequencer can register a request. They also assume that CLK_DIV is at least 1, so each half period lasts at least one clock. The stimulus writes registers only at falling clock edges, one write per task call. It changes the polarity bit only while the sequencer is idle, or together with the trigger write, so the receiver model in the bench sees a clean sequence. The side-band lines are driven as static levels during each test, so a captured image can be predicted exactly.

// File: rtl/ledchain_pkg.sv
package ledchain_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 5;
    localparam int unsigned GROUP_SZ = 8;
    localparam int unsigned GRP_W    = 3;
    localparam int unsigned CHAIN_W  = GROUP_SZ * GRP_W;
    localparam int unsigned LEN_W    = $clog2(CHAIN_W + 1);
    localparam int unsigned PHY_N    = 4;
    localparam int unsigned PHY_W    = 3;
    localparam int unsigned DSL_W    = 2;
    localparam int unsigned OWN_W    = DSL_W + PHY_N * PHY_W;
    localparam int unsigned RATE_W   = 5;

    localparam logic [ADDR_W-1:0] OFS_CTLA  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CTLB  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_DATA0 = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_DATA1 = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_ACC   = 5'h10;

    localparam logic [DATA_W-1:0] CTLA_RST = 32'h8000_0000;
    localparam int unsigned SWU_BIT = 31;
    localparam int unsigned POL_BIT = 26;

    localparam logic [1:0] SRC_BUSCLK = 2'b10;
    localparam logic [RATE_W-1:0] RATE_4HZ  = 5'd1;
    localparam logic [RATE_W-1:0] RATE_8HZ  = 5'd2;
    localparam logic [RATE_W-1:0] RATE_10HZ = 5'd3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_SAMPLE,
        S_STORE_A,
        S_STORE_B
    } seq_state_e;

    function automatic logic [LEN_W-1:0] chain_len(input logic [GRP_W-1:0] grp);
        logic [LEN_W-1:0] n;
        n = '0;
        for (int g = 0; g < int'(GRP_W); g++) begin
            if (grp[g]) n = LEN_W'((g + 1) * GROUP_SZ);
        end
        return n;
    endfunction
endpackage

// File: rtl/ledchain_regs.sv
module ledchain_regs
    import ledchain_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [CHAIN_W-1:0]  img_data,
    output logic [DSL_W-1:0]    dsl_own,
    output logic [PHY_N*PHY_W-1:0] phy_own,
    output logic [GRP_W-1:0]    grp_en,
    output logic                pol,
    output logic [1:0]          tmr_src,
    output logic [RATE_W-1:0]   rate_code,
    output logic                sw_req
);
    logic [DATA_W-1:0] ctla_q, ctlb_q, data0_q, data1_q, acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctla_q  <= CTLA_RST;
            ctlb_q  <= '0;
            data0_q <= '0;
            data1_q <= '0;
            acc_q   <= '0;
            sw_req  <= 1'b0;
        end else begin
            sw_req <= bus_we && (bus_addr == OFS_CTLA) && bus_wdata[SWU_BIT];
            if (bus_we) begin
                case (bus_addr)
                    OFS_CTLA:  ctla_q  <= bus_wdata;
                    OFS_CTLB:  ctlb_q  <= bus_wdata;
                    OFS_DATA0: data0_q <= bus_wdata;
                    OFS_DATA1: data1_q <= bus_wdata;
                    OFS_ACC:   acc_q   <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_CTLA:  bus_rdata = ctla_q;
            OFS_CTLB:  bus_rdata = ctlb_q;
            OFS_DATA0: bus_rdata = data0_q;
            OFS_DATA1: bus_rdata = data1_q;
            OFS_ACC:   bus_rdata = acc_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign img_data  = data0_q[CHAIN_W-1:0];
    assign dsl_own   = ctla_q[25:24];
    assign phy_own   = {ctlb_q[17:15], ctlb_q[8:6], ctlb_q[5:3], ctla_q[29:27]};
    assign grp_en    = ctlb_q[GRP_W-1:0];
    assign pol       = ctla_q[POL_BIT];
    assign tmr_src   = ctlb_q[31:30];
    assign rate_code = ctlb_q[27:23];

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(data0_q)); // R1
endmodule

// File: rtl/ledchain_mux.sv
module ledchain_mux
    import ledchain_pkg::*;
(
    input  logic [CHAIN_W-1:0]      img_data,
    input  logic [DSL_W-1:0]        dsl_own,
    input  logic [PHY_N*PHY_W-1:0]  phy_own,
    input  logic [DSL_W-1:0]        dsl_in,
    input  logic [PHY_N*PHY_W-1:0]  phy_in,
    output logic [CHAIN_W-1:0]      img_out
);
    logic [OWN_W-1:0] own_sel;
    logic [OWN_W-1:0] hw_val;

    assign own_sel = {phy_own, dsl_own};
    assign hw_val  = {phy_in, dsl_in};

    for (genvar b = 0; b < int'(CHAIN_W); b++) begin : g_bit
        if (b < int'(OWN_W)) begin : g_owned
            assign img_out[b] = own_sel[b] ? hw_val[b] : img_data[b];
        end else begin : g_cpu
            assign img_out[b] = img_data[b];
        end
    end
endmodule

// File: rtl/ledchain_tick.sv
module ledchain_tick
    import ledchain_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 100_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        tmr_src,
    input  logic [RATE_W-1:0] rate_code,
    output logic              tick
);
    localparam int unsigned LIM_2HZ  = TICKS_PER_SEC / 2;
    localparam int unsigned LIM_4HZ  = TICKS_PER_SEC / 4;
    localparam int unsigned LIM_8HZ  = TICKS_PER_SEC / 8;
    localparam int unsigned LIM_10HZ = TICKS_PER_SEC / 10;
    localparam int unsigned CNT_W    = $clog2(LIM_2HZ + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic             run;

    assign run = (tmr_src == SRC_BUSCLK);

    always_comb begin
        case (rate_code)
            RATE_4HZ:  lim = CNT_W'(LIM_4HZ);
            RATE_8HZ:  lim = CNT_W'(LIM_8HZ);
            RATE_10HZ: lim = CNT_W'(LIM_10HZ);
            default:   lim = CNT_W'(LIM_2HZ);
        endcase
    end

    assign tick = run && (cnt_q >= lim - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (!run)      cnt_q <= '0;
        else if (tick)      cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0)); // R9
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(LIM_2HZ)); // R9
endmodule

// File: rtl/ledchain_shift.sv
module ledchain_shift
    import ledchain_pkg::*;
#(
    parameter int unsigned CLK_DIV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [CHAIN_W-1:0] img,
    input  logic [GRP_W-1:0]   grp_en,
    input  logic               pol,
    output logic               ser_dout,
    output logic               ser_clk,
    output logic               ser_store
);
    localparam int unsigned HC_W = $clog2(CLK_DIV) + 1;
    localparam logic [HC_W-1:0] HC_LOAD = HC_W'(CLK_DIV - 1);

    seq_state_e         state_q, state_d;
    logic [HC_W-1:0]    hcnt_q;
    logic [LEN_W-1:0]   left_q;
    logic [LEN_W-1:0]   len;
    logic [CHAIN_W-1:0] sh_q;
    logic               pend_q, pol_q, half_done, start;

    assign len       = chain_len(grp_en);
    assign half_done = (hcnt_q == '0);
    assign start     = (state_q == S_IDLE) && pend_q && (len != '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start)     state_d = S_SETUP;
            S_SETUP:   if (half_done) state_d = S_SAMPLE;
            S_SAMPLE:  if (half_done) state_d = (left_q == LEN_W'(1)) ? S_STORE_A : S_SETUP;
            S_STORE_A: if (half_done) state_d = S_STORE_B;
            S_STORE_B: if (half_done) state_d = S_IDLE;
            default:                  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt_q <= HC_LOAD;
            left_q <= '0;
            sh_q   <= '0;
            pend_q <= 1'b0;
            pol_q  <= 1'b0;
        end else begin
            pend_q <= (pend_q && (state_q != S_IDLE)) || req;
            if (state_q == S_IDLE) pol_q <= pol;
            if (state_d != state_q)  hcnt_q <= HC_LOAD;
            else if (!half_done)     hcnt_q <= hcnt_q - 1'b1;
            if (start) begin
                sh_q   <= img << (LEN_W'(CHAIN_W) - len);
                left_q <= len;
            end else if ((state_q == S_SAMPLE) && half_done) begin
                sh_q   <= sh_q << 1;
                left_q <= left_q - 1'b1;
            end
        end
    end

    always_comb begin
        ser_clk   = pol_q;
        ser_dout  = 1'b0;
        ser_store = 1'b0;
        unique case (state_q)
            S_SETUP:   ser_dout = sh_q[CHAIN_W-1];
            S_SAMPLE: begin
                ser_dout = sh_q[CHAIN_W-1];
                ser_clk  = ~pol_q;
            end
            S_STORE_A, S_STORE_B: ser_store = 1'b1;
            default: ;
        endcase
    end

    AST_DOUT_STABLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_SAMPLE) && ($past(state_q) == S_SETUP)) |-> $stable(ser_dout)); // R4
    AST_STORE_FULL_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_store) |=> ser_store); // R7
    AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (state_q != S_IDLE)) |=> pend_q); // R8
    AST_LEFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= LEN_W'(CHAIN_W)); // R3
endmodule

// File: rtl/ledchain_ctrl.sv
module ledchain_ctrl
    import ledchain_pkg::*;
#(
    parameter int unsigned CLK_DIV       = 4,
    parameter int unsigned TICKS_PER_SEC = 100_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  bus_addr,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [1:0]  dsl_in,
    input  logic [11:0] phy_in,
    output logic        ser_dout,
    output logic        ser_clk,
    output logic        ser_store
);
    logic [CHAIN_W-1:0]     img_data, img_out;
    logic [DSL_W-1:0]       dsl_own;
    logic [PHY_N*PHY_W-1:0] phy_own;
    logic [GRP_W-1:0]       grp_en;
    logic                   pol, sw_req, tick;
    logic [1:0]             tmr_src;
    logic [RATE_W-1:0]      rate_code;

    ledchain_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .img_data(img_data),
        .dsl_own(dsl_own), .phy_own(phy_own), .grp_en(grp_en), .pol(pol),
        .tmr_src(tmr_src), .rate_code(rate_code), .sw_req(sw_req)
    );

    ledchain_mux u_mux (
        .img_data(img_data), .dsl_own(dsl_own), .phy_own(phy_own),
        .dsl_in(dsl_in), .phy_in(phy_in), .img_out(img_out)
    );

    ledchain_tick #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_tick (
        .clk(clk), .rst_n(rst_n), .tmr_src(tmr_src), .rate_code(rate_code), .tick(tick)
    );

    ledchain_shift #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .req(sw_req || tick), .img(img_out),
        .grp_en(grp_en), .pol(pol), .ser_dout(ser_dout), .ser_clk(ser_clk),
        .ser_store(ser_store)
    );
endmodule

// File: tb/test_ledchain_ctrl.sv
`timescale 1ns/1ps
module test_ledchain_ctrl;
    localparam int CLK_DIV = 2;
    localparam int TPS     = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  dsl_in = '0;
    logic [11:0] phy_in = '0;
    logic        ser_dout, ser_clk, ser_store;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int store_cnt = 0;
    int last_rise = 0;
    int hi_run = 0;
    int last_w = 0;
    logic tb_pol = 1'b0;
    logic st_prev = 1'b0;
    logic [23:0] rx_sh = '0;
    logic [23:0] rx_latch = '0;

    always #5 clk = ~clk;

    ledchain_ctrl #(.CLK_DIV(CLK_DIV), .TICKS_PER_SEC(TPS)) i_ledchain_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dsl_in(dsl_in),
        .phy_in(phy_in), .ser_dout(ser_dout), .ser_clk(ser_clk), .ser_store(ser_store)
    );

    // external chain model
    always @(posedge ser_clk) if (!tb_pol) rx_sh <= {rx_sh[22:0], ser_dout};
    always @(negedge ser_clk) if (tb_pol)  rx_sh <= {rx_sh[22:0], ser_dout};

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        st_prev <= ser_store;
        if (ser_store && !st_prev) begin
            store_cnt <= store_cnt + 1;
            last_rise <= cyc;
            rx_latch  <= rx_sh;
        end
        if (ser_store) hi_run <= hi_run + 1;
        else begin
            if (hi_run != 0) last_w <= hi_run;
            hi_run <= 0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_store(input int target, input int limit, input string req);
        int n;
        n = 0;
        while (store_cnt < target && n < limit) begin
            @(negedge clk);
            n++;
        end
        wcyc(2);
        check(store_cnt >= target, req, store_cnt, target);
    endtask

    function automatic logic [31:0] mk_a(input logic pol, input logic [1:0] dsl, input logic [2:0] p1);
        return 32'h8000_0000 | (32'(p1) << 27) | (32'(pol) << 26) | (32'(dsl) << 24);
    endfunction

    function automatic logic [31:0] mk_b(input logic [1:0] src, input logic [4:0] rate,
                                         input logic [2:0] p4, input logic [2:0] p3,
                                         input logic [2:0] p2, input logic [2:0] grp);
        return (32'(src) << 30) | (32'(rate) << 23) | (32'(p4) << 15) |
               (32'(p3) << 6) | (32'(p2) << 3) | 32'(grp);
    endfunction

    function automatic logic [23:0] model_img(input logic [23:0] d, input logic [1:0] dsl_o,
                                              input logic [11:0] phy_o, input logic [1:0] dsl,
                                              input logic [11:0] phy);
        logic [13:0] own;
        logic [13:0] hw;
        logic [23:0] r;
        own = {phy_o, dsl_o};
        hw  = {phy, dsl};
        r = d;
        for (int i = 0; i < 14; i++) if (own[i]) r[i] = hw[i];
        return r;
    endfunction

    task automatic shift_case(input logic [31:0] ctla, input logic [23:0] exp,
                              input int len, input string req);
        int base;
        logic [23:0] m;
        base = store_cnt;
        m = (len == 24) ? 24'hFF_FFFF : ((24'h1 << len) - 24'h1);
        bus_write(5'h00, ctla);
        wait_store(base + 1, 400, req);
        wcyc(2 * CLK_DIV + 2);
        check((rx_latch & m) == (exp & m), req, rx_latch & m, exp & m);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        bus_read(5'h00, d); check(d == 32'h8000_0000, "R1 ctla reset", d, 32'h8000_0000);
        bus_read(5'h04, d); check(d == 0, "R1 ctlb reset", d, 0);
        bus_read(5'h08, d); check(d == 0, "R1 data0 reset", d, 0);
        bus_read(5'h0C, d); check(d == 0, "R1 data1 reset", d, 0);
        bus_read(5'h10, d); check(d == 0, "R1 access reset", d, 0);
        check(ser_store == 1'b0, "R7 store idle", 32'(ser_store), 0);
        check(ser_clk == 1'b0, "R4 idle low", 32'(ser_clk), 0);
    endtask

    task automatic t_readback;
        logic [31:0] d;
        bus_write(5'h08, 32'hDEAD_BEEF); bus_read(5'h08, d);
        check(d == 32'hDEAD_BEEF, "R1 data0", d, 32'hDEAD_BEEF);
        bus_write(5'h0C, 32'h1357_9BDF); bus_read(5'h0C, d);
        check(d == 32'h1357_9BDF, "R1 data1", d, 32'h1357_9BDF);
        bus_write(5'h10, 32'h0000_00A5); bus_read(5'h10, d);
        check(d == 32'h0000_00A5, "R1 access", d, 32'h0000_00A5);
        check(store_cnt == 0, "R2 no trigger", store_cnt, 0);
    endtask

    task automatic t_basic;
        bus_write(5'h04, mk_b(2'b00, 5'd0, 3'd0, 3'd0, 3'd0, 3'b001));
        bus_write(5'h08, 32'h0000_005A);
        shift_case(mk_a(1'b0, 2'b00, 3'd0), 24'h5A, 8, "R2 pattern 5A");
        check(last_w == 2 * CLK_DIV, "R7 store width", last_w, 2 * CLK_DIV);
        bus_write(5'h08, 32'h0000_0001);
        shift_case(mk_a(1'b0, 2'b00, 3'd0), 24'h01, 8, "R2 bit0 first output");
    endtask

    task automatic t_groups;
        int base;
        bus_write(5'h08, 32'h0012_3456);
        bus_write(5'h04, mk_b(2'b00, 5'd0, 3'd0, 3'd0, 3'd0, 3'b010));
        shift_case(mk_a(1'b0, 2'b00, 3'd0), 24'h123456, 16, "R3 two groups");
        rx_sh = 24'h0;
        bus_write(5'h04, mk_b(2'b00, 5'd0, 3'd0, 3'd0, 3'd0, 3'b101));
        shift_case(mk_a(1'b0, 2'b00, 3'd0), 24'h123456, 24, "R3 three groups");
        bus_write(5'h04, mk_b(2'b00, 5'd0, 3'd0, 3'd0, 3'd0, 3'b000));
        base = store_cnt;
        bus_write(5'h00, mk_a(1'b0, 2'b00, 3'd0));
        wcyc(300);
        check(store_cnt == base, "R3 no group no store", store_cnt, base);
    endtask

    task automatic t_polarity;
        bus_write(5'h04, mk_b(2'b00, 5'd0, 3'd0, 3'd0, 3'd0, 3'b001));
        bus_write(5'h08, 32'h0000_00C3);
        tb_pol = 1'b1;
        shift_case(mk_a(1'b1, 2'b00, 3'd0), 24'hC3, 8, "R4 falling edge");
        check(ser_clk == 1'b1, "R4 idle high", 32'(ser_clk), 1);
        bus_write(5'h08, 32'h0000_003C);
        shift_case(mk_a(1'b1, 2'b00, 3'd0), 24'h3C, 8, "R4 falling edge 2");
        tb_pol = 1'b0;
        shift_case(mk_a(1'b0, 2'b00, 3'd0), 24'h3C, 8, "R4 rising edge");
    endtask

    task automatic t_dsl;
        bus_write(5'h08, 32'h0000_0000);
        dsl_in = 2'b10;
        shift_case(mk_a(1'b0, 2'b11, 3'd0), 24'h02, 8, "R5 both owned");
        dsl_in = 2'b11;
        shift_case(mk_a(1'b0, 2'b01, 3'd0), 24'h01, 8, "R5 bit0 owned");
        shift_case(mk_a(1'b0, 2'b00, 3'd0), 24'h00, 8, "R5 dsl ignored");
        dsl_in = 2'b00;
    endtask

    task automatic t_phy;
        logic [23:0] e;
        phy_in = 12'hA5C;
        bus_write(5'h08, 32'h00F0_F0F0);
        bus_write(5'h04, mk_b(2'b00, 5'd0, 3'b001, 3'b010, 3'b111, 3'b100));
        e = model_img(24'hF0F0F0, 2'b00, {3'b001, 3'b010, 3'b111, 3'b101}, 2'b00, 12'hA5C);
        shift_case(mk_a(1'b0, 2'b00, 3'b101), e, 24, "R6 phy owned");
        phy_in = 12'h000;
        bus_write(5'h08, 32'h00FF_FFFF);
        e = model_img(24'hFFFFFF, 2'b11, {3'b111, 3'b111, 3'b111, 3'b111}, 2'b01, 12'h000);
        bus_write(5'h04, mk_b(2'b00, 5'd0, 3'b111, 3'b111, 3'b111, 3'b100));
        dsl_in = 2'b01;
        shift_case(mk_a(1'b0, 2'b11, 3'b111), e, 24, "R6 all owned");
        dsl_in = 2'b00;
    endtask

    task automatic t_pending;
        int base;
        bus_write(5'h04, mk_b(2'b00, 5'd0, 3'd0, 3'd0, 3'd0, 3'b001));
        bus_write(5'h08, 32'h0000_0011);
        base = store_cnt;
        bus_write(5'h00, mk_a(1'b0, 2'b00, 3'd0));
        wcyc(10);
        bus_write(5'h08, 32'h0000_0022);
        bus_write(5'h00, mk_a(1'b0, 2'b00, 3'd0));
        wait_store(base + 1, 200, "R8 first seq");
        check(rx_latch[7:0] == 8'h11, "R8 first image", rx_latch[7:0], 8'h11);
        wait_store(base + 2, 200, "R8 pending seq");
        wcyc(2 * CLK_DIV + 2);
        check(rx_latch[7:0] == 8'h22, "R8 second image", rx_latch[7:0], 8'h22);
        wcyc(200);
        check(store_cnt == base + 2, "R8 exactly one extra", store_cnt, base + 2);
    endtask

    task automatic t_rate(input logic [4:0] code, input int period, input string req);
        int base, t1;
        base = store_cnt;
        bus_write(5'h04, mk_b(2'b10, code, 3'd0, 3'd0, 3'd0, 3'b001));
        wait_store(base + 2, 3 * period, req);
        t1 = last_rise;
        wait_store(base + 3, 2 * period, req);
        check(last_rise - t1 == period, req, last_rise - t1, period);
    endtask

    task automatic t_timer;
        int base;
        bus_write(5'h08, 32'h0000_0081);
        t_rate(5'd3, TPS / 10, "R9 10Hz");
        t_rate(5'd1, TPS / 4, "R9 4Hz");
        t_rate(5'd2, TPS / 8, "R9 8Hz");
        t_rate(5'd0, TPS / 2, "R9 2Hz");
        t_rate(5'd6, TPS / 2, "R9 other code");
        check(rx_latch[7:0] == 8'h81, "R9 image", rx_latch[7:0], 8'h81);
        bus_write(5'h04, mk_b(2'b01, 5'd3, 3'd0, 3'd0, 3'd0, 3'b001));
        wcyc(100);
        base = store_cnt;
        wcyc(2 * TPS);
        check(store_cnt == base, "R9 other source off", store_cnt, base);
    endtask

    task automatic finish_report;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_report();
    end

    initial begin
        wcyc(3);
        rst_n = 1'b1;
        wcyc(2);
        t_reset();
        t_readback();
        t_basic();
        t_groups();
        t_polarity();
        t_dsl();
        t_phy();
        t_pending();
        t_timer();
        finish_report();
    end
endmodule